// File: doc/BRIEF.md
# Cartridge Memory Bank Mapper

This block switches memory banks for a game cartridge. The CPU writes bank numbers and mode bits into a small register set. Three address streams are then translated from those registers without any clock delay. CPU program addresses are mapped into 8 KiB pages of program ROM. Video character addresses are mapped into 4 KiB pages of character memory. Nametable addresses are folded into a 2 KiB video RAM, using one of two mirroring layouts.

The CPU window from 0x8000 to 0xDFFF is split into three switchable 8 KiB slots. Every other CPU region, including the top slot at 0xE000, is tied to page 15. Each of the two 4 KiB character windows takes a 5-bit bank number. The low nibble of that number has its own register. The top bit sits in a shared control register, which also holds the mirroring mode.

Only the low nibble of the CPU data bus reaches the block, because no register uses the upper bits. Only the low 13 bits of the video address reach the block, because translation needs no higher bit.

Top module: `bank_mapper`

## Requirements
- R1: While reset is held low, and after it is released, every bank register, both character high bits and the mirroring mode read as zero. A CPU address of 0x8123 then translates to 0x00123, and a video address of 0x1FFF translates to character address 0x00FFF.
- R2: For CPU address bits 15:13 equal to 4, 5 or 6, the program address is {slot bank, cpu_addr[12:0]}. Value 4 uses slot 0, value 5 uses slot 1 and value 6 uses slot 2.
- R3: For any other value of CPU address bits 15:13 (0 to 3 and 7), program address bits 16:13 equal 4'hF, and the low 13 bits pass through unchanged.
- R4: A strobed write with cpu_addr[15:12] equal to 8 loads slot 0 from cpu_wdata[3:0]. The value A loads slot 1, and the value C loads slot 2.
- R5: A strobed write with cpu_addr[15:12] equal to 9 sets three fields from cpu_wdata. Bit 0 sets the mirroring mode, bit 1 sets the high bank bit of the lower character window, and bit 2 sets the high bank bit of the upper character window.
- R6: A strobed write with cpu_addr[15:12] equal to E loads the low nibble of the lower character window. The value F loads the upper window.
- R7: vid_addr[12] selects the character window (0 selects lower, 1 selects upper). The character address is {high bit, low nibble, vid_addr[11:0]}.
- R8: In mirroring mode 0, nt_addr is {vid_addr[10], vid_addr[9:0]}. In mode 1, nt_addr is {vid_addr[11], vid_addr[9:0]}.
- R9: Strobed writes to cpu_addr[15:12] equal to B or D, or to any address below 0x8000, change no register.
- R10: While cpu_we is low, no register changes, whatever the address and data. Registers update only on a rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers load on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU address, used for both register decode and program translation |
| cpu_wdata | input | 4 | Low nibble of the CPU write data |
| cpu_we | input | 1 | Write strobe |
| vid_addr | input | 13 | Low 13 bits of the video address |
| prg_addr | output | 17 | Translated program ROM address |
| chr_addr | output | 17 | Translated character memory address |
| nt_addr | output | 11 | Translated nametable RAM address |

## Verification
A corrupted register shows up at the ports only when an address selects that register. A wrong slot bank appears on prg_addr bits 16:13 in the first probe of the matching 8 KiB region after the write. A wrong high bit or nibble appears on chr_addr bits 16:12 only when vid_addr[12] selects that window. A wrong mirroring mode flips nt_addr[10] only when vid_addr bits 10 and 11 differ. The bench therefore probes every region and both windows after each write, and toggles bits 10 and 11 independently. Any error then surfaces within one cycle of the edge that caused it.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
    localparam int CPU_AW     = 16;
    localparam int DATA_W     = 4;
    localparam int VID_AW     = 13;
    localparam int PRG_OFS_W  = 13;
    localparam int PRG_BANK_W = 4;
    localparam int PRG_SLOTS  = 3;
    localparam int CHR_OFS_W  = 12;
    localparam int CHR_LO_W   = 4;
    localparam int CHR_WINS   = 2;
    localparam int CHR_BANK_W = CHR_LO_W + 1;
    localparam int NT_OFS_W   = 10;
    localparam int PRG_OUT_W  = PRG_BANK_W + PRG_OFS_W;
    localparam int CHR_OUT_W  = CHR_BANK_W + CHR_OFS_W;
    localparam int NT_OUT_W   = NT_OFS_W + 1;
    localparam int DEC_W      = 4;
    localparam int REGION_W   = CPU_AW - PRG_OFS_W;
    localparam logic [PRG_BANK_W-1:0] FIXED_PAGE = '1;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_PRG0,
        TGT_PRG1,
        TGT_PRG2,
        TGT_CTRL,
        TGT_CHR_LO0,
        TGT_CHR_LO1
    } wr_target_e;

    typedef struct packed {
        logic [PRG_SLOTS-1:0][PRG_BANK_W-1:0] prg_pg;
        logic [CHR_WINS-1:0][CHR_LO_W-1:0]    chr_lo;
        logic [CHR_WINS-1:0]                  chr_hi;
        logic                                 mirror_h;
    } map_regs_t;
endpackage

// File: rtl/bank_mapper_regs.sv
module bank_mapper_regs
    import bank_mapper_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEC_W-1:0]  dec_nib,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    output map_regs_t         regs_q
);
    wr_target_e tgt;

    // register decode from the top nibble of the CPU address
    always_comb begin
        unique case (dec_nib)
            4'h8:    tgt = TGT_PRG0;
            4'h9:    tgt = TGT_CTRL;
            4'hA:    tgt = TGT_PRG1;
            4'hC:    tgt = TGT_PRG2;
            4'hE:    tgt = TGT_CHR_LO0;
            4'hF:    tgt = TGT_CHR_LO1;
            default: tgt = TGT_NONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (we) begin
            unique case (tgt)
                TGT_PRG0:    regs_q.prg_pg[0] <= wdata[PRG_BANK_W-1:0];
                TGT_PRG1:    regs_q.prg_pg[1] <= wdata[PRG_BANK_W-1:0];
                TGT_PRG2:    regs_q.prg_pg[2] <= wdata[PRG_BANK_W-1:0];
                TGT_CTRL: begin
                    regs_q.mirror_h  <= wdata[0];
                    regs_q.chr_hi[0] <= wdata[1];
                    regs_q.chr_hi[1] <= wdata[2];
                end
                TGT_CHR_LO0: regs_q.chr_lo[0] <= wdata[CHR_LO_W-1:0];
                TGT_CHR_LO1: regs_q.chr_lo[1] <= wdata[CHR_LO_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bank_mapper_prg.sv
module bank_mapper_prg
    import bank_mapper_pkg::*;
(
    input  logic [CPU_AW-1:0]                     cpu_addr,
    input  logic [PRG_SLOTS-1:0][PRG_BANK_W-1:0]  prg_pg,
    output logic [PRG_OUT_W-1:0]                  prg_addr
);
    localparam int FIRST_SW_REGION = 4;

    logic [REGION_W-1:0]   region;
    logic [PRG_BANK_W-1:0] bank;
    logic [PRG_SLOTS-1:0]  hit;

    assign region = cpu_addr[CPU_AW-1:PRG_OFS_W];

    for (genvar s = 0; s < PRG_SLOTS; s++) begin : g_slot
        assign hit[s] = (region == REGION_W'(FIRST_SW_REGION + s));
    end

    always_comb begin
        bank = FIXED_PAGE;
        for (int s = 0; s < PRG_SLOTS; s++) begin
            if (hit[s]) bank = prg_pg[s];
        end
    end

    assign prg_addr = {bank, cpu_addr[PRG_OFS_W-1:0]};
endmodule

// File: rtl/bank_mapper_chr.sv
module bank_mapper_chr
    import bank_mapper_pkg::*;
(
    input  logic [CHR_OFS_W:0]                  vid_lo,
    input  logic [CHR_WINS-1:0][CHR_LO_W-1:0]   chr_lo,
    input  logic [CHR_WINS-1:0]                 chr_hi,
    output logic [CHR_OUT_W-1:0]                chr_addr
);
    logic                  win;
    logic [CHR_BANK_W-1:0] bank;

    assign win      = vid_lo[CHR_OFS_W];
    assign bank     = {chr_hi[win], chr_lo[win]};
    assign chr_addr = {bank, vid_lo[CHR_OFS_W-1:0]};
endmodule

// File: rtl/bank_mapper_nt.sv
module bank_mapper_nt
    import bank_mapper_pkg::*;
(
    input  logic [NT_OFS_W+1:0]  vid_nt,
    input  logic                 mirror_h,
    output logic [NT_OUT_W-1:0]  nt_addr
);
    logic page;

    always_comb begin
        unique case (mirror_h)
            1'b0: page = vid_nt[NT_OFS_W];
            1'b1: page = vid_nt[NT_OFS_W+1];
        endcase
    end

    assign nt_addr = {page, vid_nt[NT_OFS_W-1:0]};
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import bank_mapper_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CPU_AW-1:0]     cpu_addr,
    input  logic [DATA_W-1:0]     cpu_wdata,
    input  logic                  cpu_we,
    input  logic [VID_AW-1:0]     vid_addr,
    output logic [PRG_OUT_W-1:0]  prg_addr,
    output logic [CHR_OUT_W-1:0]  chr_addr,
    output logic [NT_OUT_W-1:0]   nt_addr
);
    map_regs_t regs_q;

    bank_mapper_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .dec_nib (cpu_addr[CPU_AW-1:CPU_AW-DEC_W]),
        .wdata   (cpu_wdata),
        .we      (cpu_we),
        .regs_q  (regs_q)
    );

    bank_mapper_prg u_prg (
        .cpu_addr (cpu_addr),
        .prg_pg   (regs_q.prg_pg),
        .prg_addr (prg_addr)
    );

    bank_mapper_chr u_chr (
        .vid_lo   (vid_addr[CHR_OFS_W:0]),
        .chr_lo   (regs_q.chr_lo),
        .chr_hi   (regs_q.chr_hi),
        .chr_addr (chr_addr)
    );

    bank_mapper_nt u_nt (
        .vid_nt   (vid_addr[NT_OFS_W+1:0]),
        .mirror_h (regs_q.mirror_h),
        .nt_addr  (nt_addr)
    );
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk
    import bank_mapper_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [CPU_AW-1:0]     cpu_addr,
    input logic [DATA_W-1:0]     cpu_wdata,
    input logic                  cpu_we,
    input logic [VID_AW-1:0]     vid_addr,
    input logic [PRG_OUT_W-1:0]  prg_addr,
    input logic [CHR_OUT_W-1:0]  chr_addr,
    input logic [NT_OUT_W-1:0]   nt_addr,
    input map_regs_t             regs
);
    logic [DEC_W-1:0] nib;
    assign nib = cpu_addr[CPU_AW-1:CPU_AW-DEC_W];

    // R3
    a_r3_fixed_top: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'd7) |-> (prg_addr[16:13] == 4'hF));

    // R2
    a_r2_slot1_map: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'd5) |-> (prg_addr == {regs.prg_pg[1], cpu_addr[12:0]}));

    // R4
    a_r4_slot0_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && nib == 4'h8) |=> (regs.prg_pg[0] == $past(cpu_wdata)));

    // R5
    a_r5_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && nib == 4'h9) |=>
        ({regs.chr_hi[1], regs.chr_hi[0], regs.mirror_h} == $past(cpu_wdata[2:0])));

    // R7
    a_r7_chr_offset: assert property (@(posedge clk) disable iff (!rst_n)
        chr_addr[11:0] == vid_addr[11:0]);

    // R8
    a_r8_vert_page: assert property (@(posedge clk) disable iff (!rst_n)
        !regs.mirror_h |-> (nt_addr == {vid_addr[10], vid_addr[9:0]}));

    // R9
    a_r9_dead_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && (nib == 4'hB || nib == 4'hD || !nib[3])) |=> (regs == $past(regs)));

    // R10
    a_r10_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_we |=> $stable(regs));
endmodule

bind bank_mapper bank_mapper_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_we    (cpu_we),
    .vid_addr  (vid_addr),
    .prg_addr  (prg_addr),
    .chr_addr  (chr_addr),
    .nt_addr   (nt_addr),
    .regs      (regs_q)
);

// File: tb/sim_bank_mapper.sv
`timescale 1ns/1ps
module sim_bank_mapper;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [3:0]  cpu_wdata = '0;
    logic        cpu_we = 1'b0;
    logic [12:0] vid_addr = '0;
    logic [16:0] prg_addr;
    logic [16:0] chr_addr;
    logic [10:0] nt_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_mapper u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .vid_addr(vid_addr), .prg_addr(prg_addr),
        .chr_addr(chr_addr), .nt_addr(nt_addr)
    );

    // reference register model, from the requirements
    logic [3:0] m_slot [3];
    logic [3:0] m_lo [2];
    logic       m_hi [2];
    logic       m_mir;

    typedef struct packed {
        logic [16:0] ep;
        logic [16:0] ec;
        logic [10:0] en;
    } exp_t;

    exp_t  sb_q[$];
    string tag_q[$];
    event  chk_ev;

    function automatic logic [16:0] exp_prg(logic [15:0] a);
        logic [3:0] b;
        case (a[15:13])
            3'd4: b = m_slot[0];
            3'd5: b = m_slot[1];
            3'd6: b = m_slot[2];
            default: b = 4'hF;
        endcase
        return {b, a[12:0]};
    endfunction

    function automatic logic [16:0] exp_chr(logic [12:0] v);
        int w = v[12] ? 1 : 0;
        return {m_hi[w], m_lo[w], v[11:0]};
    endfunction

    function automatic logic [10:0] exp_nt(logic [12:0] v);
        return m_mir ? {v[11], v[9:0]} : {v[10], v[9:0]};
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 3; i++) m_slot[i] = '0;
        for (int i = 0; i < 2; i++) begin m_lo[i] = '0; m_hi[i] = 1'b0; end
        m_mir = 1'b0;
    endtask

    // driver: set inputs, push expected item, wake the monitor
    task automatic probe(string tag, logic [15:0] a, logic [12:0] v);
        exp_t e;
        @(negedge clk);
        cpu_we = 1'b0;
        cpu_addr = a;
        vid_addr = v;
        e.ep = exp_prg(a);
        e.ec = exp_chr(v);
        e.en = exp_nt(v);
        sb_q.push_back(e);
        tag_q.push_back(tag);
        #1;
        -> chk_ev;
        #1;
    endtask

    task automatic cpu_write(logic [15:0] a, logic [3:0] d, logic strobe);
        @(negedge clk);
        cpu_addr = a;
        cpu_wdata = d;
        cpu_we = strobe;
        @(posedge clk);
        if (strobe) begin
            case (a[15:12])
                4'h8: m_slot[0] = d;
                4'hA: m_slot[1] = d;
                4'hC: m_slot[2] = d;
                4'h9: begin m_mir = d[0]; m_hi[0] = d[1]; m_hi[1] = d[2]; end
                4'hE: m_lo[0] = d;
                4'hF: m_lo[1] = d;
                default: ;
            endcase
        end
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    // monitor: pop and compare
    initial begin
        forever begin
            exp_t  e;
            string t;
            @(chk_ev);
            e = sb_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (prg_addr !== e.ep || chr_addr !== e.ec || nt_addr !== e.en) begin
                failures++;
                $display("FAIL %s: prg=%05h chr=%05h nt=%03h expected prg=%05h chr=%05h nt=%03h",
                         t, prg_addr, chr_addr, nt_addr, e.ep, e.ec, e.en);
            end
        end
    end

    task automatic lit_check(string tag, logic [16:0] act, logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%05h expected=%05h", tag, act, exp);
        end
    endtask

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        // R1: during reset, try a write that must not land
        cpu_write(16'h8000, 4'h9, 1'b1);
        model_clear();
        probe("R1 in reset", 16'h8123, 13'h1FFF);
        @(negedge clk);
        rst_n = 1'b1;
        probe("R1 after reset", 16'h8123, 13'h1FFF);
        lit_check("R1 literal prg", prg_addr, 17'h00123);
        lit_check("R1 literal chr", chr_addr, 17'h00FFF);
        probe("R1 vert nt", 16'hA000, 13'h0C00);

        // R4 slot loads
        cpu_write(16'h8000, 4'h3, 1'b1);
        cpu_write(16'hA5A5, 4'h7, 1'b1);
        cpu_write(16'hCFFF, 4'hC, 1'b1);
        probe("R4 R2 slot0", 16'h8ABC, 13'h0000);
        lit_check("R2 literal slot0", prg_addr, 17'h06ABC);
        probe("R4 R2 slot1", 16'hBFFF, 13'h0000);
        probe("R4 R2 slot2", 16'hC001, 13'h0000);
        lit_check("R2 literal slot2", prg_addr, 17'h18001);
        // R3 fixed regions
        probe("R3 top", 16'hE123, 13'h0000);
        lit_check("R3 literal top", prg_addr, 17'h1E123);
        probe("R3 low", 16'h0042, 13'h0000);
        probe("R3 6000", 16'h7FFF, 13'h0000);

        // R5 control, R6 nibbles
        cpu_write(16'h9000, 4'h6, 1'b1);
        cpu_write(16'hE000, 4'hA, 1'b1);
        cpu_write(16'hF123, 4'h5, 1'b1);
        probe("R5 R6 R7 lower", 16'h8000, 13'h0123);
        lit_check("R7 literal lower", chr_addr, 17'h1A123);
        probe("R5 R6 R7 upper", 16'h8000, 13'h1ABC);
        lit_check("R7 literal upper", chr_addr, 17'h15ABC);
        cpu_write(16'h9FFF, 4'h2, 1'b1);
        probe("R5 hi lower only", 16'h8000, 13'h1ABC);
        probe("R5 hi lower only b", 16'h8000, 13'h0ABC);

        // R8 mirroring
        probe("R8 vert 400", 16'h8000, 13'h0400);
        probe("R8 vert 800", 16'h8000, 13'h0800);
        cpu_write(16'h9000, 4'h1, 1'b1);
        probe("R8 horiz 400", 16'h8000, 13'h0400);
        probe("R8 horiz 800", 16'h8000, 13'h0800);
        lit_check("R8 literal horiz", {6'd0, nt_addr}, 17'h00400);
        probe("R8 horiz 3FF", 16'h8000, 13'h0FFF);

        // R9 dead writes
        cpu_write(16'hB000, 4'hF, 1'b1);
        cpu_write(16'hD7FF, 4'hF, 1'b1);
        cpu_write(16'h7000, 4'hF, 1'b1);
        cpu_write(16'h0000, 4'hF, 1'b1);
        for (int r = 0; r < 8; r++) begin
            probe("R9 unchanged", {r[2:0], 13'h0155}, {r[0], 12'hC55});
        end

        // R10 no strobe
        cpu_write(16'h8000, 4'h9, 1'b0);
        cpu_write(16'h9000, 4'h0, 1'b0);
        cpu_write(16'hF000, 4'h0, 1'b0);
        probe("R10 slot0 held", 16'h8000, 13'h1000);
        probe("R10 ctrl held", 16'h8000, 13'h0800);

        // sweep: many write/probe patterns
        for (int k = 0; k < 40; k++) begin
            logic [15:0] wa;
            logic [3:0]  nibs [8];
            nibs = '{4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF};
            wa = {nibs[k % 8], 12'(k * 37)};
            cpu_write(wa, 4'(k * 7 + 3), 1'b1);
            probe("R2 R7 R8 sweep", 16'(k * 16'h0731), 13'(k * 13'h0295));
        end

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule